// File: doc/BRIEF.md
# Keyed Watchdog Interval Timer

This block is an 8-bit up-counter that works as a periodic interval timer. A prescaler divides the peripheral clock by 32 shifted left by a 3-bit select, so a count tick lasts between 32 and 4096 clocks. While the enable bit in the control byte is set, the counter advances by one on each tick. When it wraps from 0xFF to 0x00, a sticky overflow flag is set and a single-cycle interrupt request is raised. The request carries a priority level and a vector taken from two configuration bytes that sit outside the block.

Software cannot change either register with an ordinary store. Only a 16-bit write is accepted, and its upper byte must be a key. One key value selects the control byte and another selects the counter. The low byte of the write is the payload. Both registers can be read back as plain bytes at all times.

Top module: `wdog_interval_timer`

## Requirements
- R1: After reset the control byte, the counter and the interrupt request are all zero.
- R2: A 16-bit write with upper byte 0xA5 loads payload bits 6:0 into control bits 6:0. Control bit 7 can only be kept (payload bit 7 = 1) or cleared (payload bit 7 = 0); such a write never sets it.
- R3: A 16-bit write with upper byte 0x5A loads the payload byte into the counter.
- R4: A write that is not 16 bits wide (`wr_half` = 0), or a 16-bit write whose upper byte is neither key, changes neither register.
- R5: Control bits 2:0 give a select s. While the timer runs, the counter advances once every 32 << s clocks. The first advance comes 32 << s clocks after the keyed control write that enabled it.
- R6: Control bit 5 is the run enable. While it is 0 the counter holds its value and the prescaler stays at zero.
- R7: Every keyed control write restarts the prescaler from zero, so the next advance comes a full period after that write.
- R8: When the counter wraps from 0xFF to 0x00, control bit 7 is set in that same clock. It stays set until a keyed control write with payload bit 7 = 0.
- R9: In the clock after a wrap, `irq_req` is high for exactly one cycle. During that cycle `irq_level` equals bits 7:4 of `prio_byte` and `irq_vector` equals bits 6:0 of `vector_reg`, both as they were when the wrap happened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the timer registers |
| wr_half | input | 1 | 1 when the write is 16 bits wide |
| wr_data | input | 16 | Key in bits 15:8, payload in bits 7:0 |
| prio_byte | input | 8 | Priority configuration; bits 7:4 give the level |
| vector_reg | input | 8 | Vector configuration; bits 6:0 give the vector |
| ctrl_rd | output | 8 | Control byte: 7 overflow, 5 enable, 2:0 select |
| count_rd | output | 8 | Current counter value |
| irq_req | output | 1 | One-cycle overflow interrupt request |
| irq_level | output | 4 | Level captured at overflow |
| irq_vector | output | 7 | Vector captured at overflow |

## Verification
The assertions assume that `wr_en` and `wr_data` are clean, synchronous values on each rising edge, and that `prio_byte` and `vector_reg` are valid at the edge where a wrap happens. The bench sets every input on the falling edge and keeps writes to single-cycle strobes. It only changes the priority and vector bytes while the timer is stopped, and it reads the counter only on falling edges, so wraps and reloads never race with sampling.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] KEY_CTRL  = 8'hA5;
    localparam logic [BYTE_W-1:0] KEY_COUNT = 8'h5A;

    localparam int CTRL_OVF_BIT = 7;
    localparam int CTRL_EN_BIT  = 5;
    localparam int SEL_W        = 3;

    typedef struct packed {
        logic              ctrl_wr;
        logic              count_wr;
        logic [BYTE_W-1:0] payload;
    } wdog_wr_t;

endpackage

// File: rtl/wdog_key_decode.sv
module wdog_key_decode
    import wdog_pkg::*;
(
    input  logic                wr_en,
    input  logic                wr_half,
    input  logic [2*BYTE_W-1:0] wr_data,
    output wdog_wr_t            wr_o
);

    logic [BYTE_W-1:0] key;
    logic              keyed;

    always_comb begin
        key           = wr_data[2*BYTE_W-1:BYTE_W];
        keyed         = wr_en && wr_half;
        wr_o.payload  = wr_data[BYTE_W-1:0];
        wr_o.ctrl_wr  = keyed && (key == KEY_CTRL);
        wr_o.count_wr = keyed && (key == KEY_COUNT);
    end

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int BASE_LOG2 = 5,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int PRE_W = BASE_LOG2 + (1 << SEL_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [PRE_W-1:0] limit;
    logic             at_limit;

    always_comb begin
        limit    = (PRE_W'(1) << (BASE_LOG2 + int'(sel))) - PRE_W'(1);
        at_limit = (st_q.pre == limit);
        tick     = run && !restart && at_limit;
        st_d     = st_q;
        if (!run || restart || at_limit) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PRE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.pre == '0)); // R6

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.pre == '0)); // R7

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = tick && !load && (&st_q.cnt);
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        count = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(st_q.cnt)); // R6

    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.cnt == $past(load_val))); // R3

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (st_q.cnt == '0)); // R8

endmodule

// File: rtl/wdog_irq_gen.sv
module wdog_irq_gen #(
    parameter int LVL_W = 4,
    parameter int VEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic [7:0]       prio_byte,
    input  logic [7:0]       vector_reg,
    output logic             irq,
    output logic [LVL_W-1:0] level,
    output logic [VEC_W-1:0] vector
);

    typedef struct packed {
        logic             irq;
        logic [LVL_W-1:0] level;
        logic [VEC_W-1:0] vector;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = wrap;
        if (wrap) begin
            st_d.level  = prio_byte[7 -: LVL_W];
            st_d.vector = vector_reg[VEC_W-1:0];
        end
        irq    = st_q.irq;
        level  = st_q.level;
        vector = st_q.vector;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq); // R9

    AST_IRQ_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (st_q.level == $past(prio_byte[7 -: LVL_W]))
              && (st_q.vector == $past(vector_reg[VEC_W-1:0]))); // R9

endmodule

// File: rtl/wdog_interval_timer.sv
module wdog_interval_timer
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_half,
    input  logic [2*BYTE_W-1:0] wr_data,
    input  logic [7:0]          prio_byte,
    input  logic [7:0]          vector_reg,
    output logic [BYTE_W-1:0]   ctrl_rd,
    output logic [BYTE_W-1:0]   count_rd,
    output logic                irq_req,
    output logic [3:0]          irq_level,
    output logic [6:0]          irq_vector
);

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
    } top_state_t;

    top_state_t st_d, st_q;
    wdog_wr_t   wr;
    logic       tick;
    logic       wrap;

    wdog_key_decode u_keys (
        .wr_en   (wr_en),
        .wr_half (wr_half),
        .wr_data (wr_data),
        .wr_o    (wr)
    );

    wdog_prescaler #(
        .BASE_LOG2 (BASE_LOG2),
        .SEL_W     (SEL_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.ctrl[CTRL_EN_BIT]),
        .restart (wr.ctrl_wr),
        .sel     (st_q.ctrl[SEL_W-1:0]),
        .tick    (tick)
    );

    wdog_counter #(
        .CNT_W (BYTE_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (wr.count_wr),
        .load_val (wr.payload),
        .count    (count_rd),
        .wrap     (wrap)
    );

    wdog_irq_gen #(
        .LVL_W (4),
        .VEC_W (7)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap       (wrap),
        .prio_byte  (prio_byte),
        .vector_reg (vector_reg),
        .irq        (irq_req),
        .level      (irq_level),
        .vector     (irq_vector)
    );

    always_comb begin
        st_d = st_q;
        if (wr.ctrl_wr) begin
            st_d.ctrl = wr.payload;
            st_d.ctrl[CTRL_OVF_BIT] = st_q.ctrl[CTRL_OVF_BIT] && wr.payload[CTRL_OVF_BIT];
        end
        if (wrap) begin
            st_d.ctrl[CTRL_OVF_BIT] = 1'b1;
        end
        ctrl_rd = st_q.ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr.ctrl_wr |=> (st_q.ctrl[CTRL_OVF_BIT-1:0] == $past(wr_data[CTRL_OVF_BIT-1:0]))); // R2

    AST_UNKEYED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_half) |=> $stable(st_q.ctrl[CTRL_OVF_BIT-1:0])); // R4

    AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> st_q.ctrl[CTRL_OVF_BIT]); // R8

    AST_FLAG_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl[CTRL_OVF_BIT] && !wrap) |=> !st_q.ctrl[CTRL_OVF_BIT]); // R2

endmodule

// File: tb/test_wdog_interval_timer.sv
`timescale 1ns/1ps
module test_wdog_interval_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_half = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  prio_byte = 8'hB3;
    logic [7:0]  vector_reg = 8'hC5;
    logic [7:0]  ctrl_rd, count_rd;
    logic        irq_req;
    logic [3:0]  irq_level;
    logic [6:0]  irq_vector;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog_interval_timer i_wdog_interval_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_half    (wr_half),
        .wr_data    (wr_data),
        .prio_byte  (prio_byte),
        .vector_reg (vector_reg),
        .ctrl_rd    (ctrl_rd),
        .count_rd   (count_rd),
        .irq_req    (irq_req),
        .irq_level  (irq_level),
        .irq_vector (irq_vector)
    );

    task automatic check(string req, string what, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // caller is at a falling edge; returns at the falling edge after the write edge
    task automatic write(logic half, logic [15:0] data);
        wr_en   = 1'b1;
        wr_half = half;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_half = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic test_reset();
        check("R1", "ctrl", ctrl_rd, 0);
        check("R1", "count", count_rd, 0);
        check("R1", "irq", irq_req, 0);
    endtask

    task automatic test_keys();
        write(1'b1, 16'h5A_3C);
        check("R3", "count load", count_rd, 8'h3C);
        write(1'b1, 16'hA5_5B);
        check("R2", "ctrl load", ctrl_rd, 8'h5B);
        write(1'b1, 16'hA5_80);
        check("R2", "bit7 not settable", ctrl_rd, 8'h00);
    endtask

    task automatic test_ignored();
        write(1'b0, 16'hA5_27);
        check("R4", "byte ctrl write", ctrl_rd, 8'h00);
        write(1'b0, 16'h5A_77);
        check("R4", "byte count write", count_rd, 8'h3C);
        write(1'b1, 16'h3C_27);
        check("R4", "bad key ctrl", ctrl_rd, 8'h00);
        write(1'b1, 16'hA4_11);
        check("R4", "bad key count", count_rd, 8'h3C);
    endtask

    task automatic test_rate(int sel);
        int period = 32 << sel;
        write(1'b1, 16'h5A_00);
        write(1'b1, 16'hA5_20 | 16'(sel));
        wait_cyc(period - 1);
        check("R5", $sformatf("sel%0d before tick", sel), count_rd, 0);
        wait_cyc(1);
        check("R5", $sformatf("sel%0d first tick", sel), count_rd, 1);
        wait_cyc(period);
        check("R5", $sformatf("sel%0d second tick", sel), count_rd, 2);
        write(1'b1, 16'hA5_00);
    endtask

    task automatic test_enable();
        write(1'b1, 16'h5A_10);
        write(1'b1, 16'hA5_00);
        wait_cyc(200);
        check("R6", "frozen while off", count_rd, 8'h10);
        write(1'b1, 16'hA5_20);
        wait_cyc(20);
        write(1'b1, 16'hA5_00);
        wait_cyc(100);
        check("R6", "frozen after stop", count_rd, 8'h10);
    endtask

    task automatic test_restart();
        write(1'b1, 16'h5A_00);
        write(1'b1, 16'hA5_20);
        wait_cyc(20);
        write(1'b1, 16'hA5_20);
        wait_cyc(31);
        check("R7", "no early tick", count_rd, 0);
        wait_cyc(1);
        check("R7", "tick after full period", count_rd, 1);
        write(1'b1, 16'hA5_00);
    endtask

    task automatic test_overflow();
        prio_byte  = 8'hB3;
        vector_reg = 8'hC5;
        write(1'b1, 16'h5A_FE);
        write(1'b1, 16'hA5_20);
        wait_cyc(63);
        check("R8", "count before wrap", count_rd, 8'hFF);
        check("R9", "irq before wrap", irq_req, 0);
        wait_cyc(1);
        check("R8", "count wrapped", count_rd, 0);
        check("R8", "flag set", ctrl_rd, 8'hA0);
        check("R9", "irq raised", irq_req, 1);
        check("R9", "level", irq_level, 4'hB);
        check("R9", "vector", irq_vector, 7'h45);
        wait_cyc(1);
        check("R9", "irq one cycle", irq_req, 0);
        check("R8", "flag sticky", ctrl_rd[7], 1);
    endtask

    task automatic test_flag_clear();
        write(1'b1, 16'hA5_A0);
        check("R8", "flag kept by bit7=1", ctrl_rd, 8'hA0);
        write(1'b1, 16'hA5_00);
        check("R8", "flag cleared by bit7=0", ctrl_rd, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_keys();
        test_ignored();
        test_rate(0);
        test_rate(3);
        test_rate(7);
        test_enable();
        test_restart();
        test_overflow();
        test_flag_clear();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule